// File: doc/BRIEF.md
# Packet Radio Transmit Framer

This block turns a frame request into the complete byte stream that a low-rate wireless personal area network transmitter sends. A caller pulses a start strobe together with a frame length. The block checks the length. It then emits a fixed synchronization header: a run of zero preamble bytes followed by a delimiter byte of 0xA7. After the header it sends the length byte itself. It then passes through the MAC bytes that the caller supplies over a valid/ready byte interface. Last, it appends a two-byte frame check sequence that it computes while those bytes stream past.

The length value counts every MAC byte including the two check bytes, so the block takes exactly length minus two bytes from its input. Outside the MAC phase the block keeps its input ready low, so the caller can hold its first byte valid at any time. The output has no backpressure. A byte is emitted in every cycle where the output valid is high, and the first and last bytes of a frame are marked. A length outside 5..127 produces a one-cycle error pulse, and nothing is sent.

The controller is a state machine with states IDLE, PREAMBLE, DELIM, LENGTH, PAYLOAD, CHECK_LO and CHECK_HI. Its transitions are:
- IDLE→PREAMBLE on an accepted start.
- PREAMBLE→DELIM after the last preamble byte.
- DELIM→LENGTH and LENGTH→PAYLOAD unconditionally.
- PAYLOAD→CHECK_LO on the transfer of the final input byte.
- CHECK_LO→CHECK_HI and CHECK_HI→IDLE unconditionally.

A start with a bad length leaves the machine in IDLE.

Top module: `pkt_tx_framer`

## Requirements
- R1: During and directly after reset, out_valid_o, in_ready_o and len_err_o are all 0.
- R2: When start_i is high in IDLE with a legal length, the next cycle begins four consecutive 0x00 bytes with out_valid_o high, and out_sof_o is high on the first of them only.
- R3: The cycle after the last preamble byte emits the delimiter 0xA7.
- R4: The cycle after the delimiter emits the length value that len_i carried when the start was accepted.
- R5: After the length byte, exactly len−2 input bytes are forwarded in order. Each input byte is output in the same cycle as its transfer (in_valid_i and in_ready_i both high). out_valid_o is low in this phase whenever in_valid_i is low.
- R6: in_ready_o is high only while the block is waiting for or taking MAC bytes.
- R7: After the last MAC byte, two check bytes follow on consecutive cycles, low byte first, with out_eof_o high on the second. The check value is a CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first as a right-shifting register with the reflected constant 0x8408. It starts at 0x0000 and covers only the MAC bytes, not the length byte.
- R8: The CRC register is cleared at every accepted start, so two frames with identical content carry identical check bytes.
- R9: A start in IDLE with len_i below 5 or above 127 raises len_err_o for exactly the next cycle. No byte is emitted, and the block stays idle.
- R10: A start_i while a frame is in progress is ignored: no error pulse, and the frame in flight is unchanged.
- R11: Outside the MAC phase, header and check bytes leave on back-to-back cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request strobe, sampled in IDLE |
| len_i | input | 8 | Frame length (MAC bytes plus two check bytes) |
| len_err_o | output | 1 | One-cycle pulse for a rejected length |
| in_data_i | input | 8 | MAC byte from the caller |
| in_valid_i | input | 1 | in_data_i holds a byte |
| in_ready_o | output | 1 | Block takes a MAC byte this cycle |
| out_data_o | output | 8 | Transmit byte |
| out_valid_o | output | 1 | out_data_o is a frame byte |
| out_sof_o | output | 1 | First byte of a frame |
| out_eof_o | output | 1 | Last byte of a frame |

## Verification
The bench builds the block with its default parameters: four preamble bytes and a legal length window of 5 to 127. With these values it can reach both window edges directly, from the shortest frame with three MAC bytes to the longest with 125. It also drives the lengths just outside the window, 4 and 128, and the extremes 0 and 255. A behavioural model holds a queue of expected bytes with their phase. Every clock, it predicts the output valid, input ready, data, markers and error pulse. It does this for frames fed back to back, frames whose input valid has gaps, repeated identical frames, and stray start strobes in mid-frame.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DELIM,
        ST_LEN,
        ST_MAC,
        ST_CHK_LO,
        ST_CHK_HI
    } txf_state_e;

    localparam int          CHK_W        = 16;
    localparam logic [15:0] CHK_POLY_REF = 16'h8408;
    localparam logic [15:0] CHK_SEED     = 16'h0000;

endpackage

// File: rtl/pkt_tx_lenchk.sv
module pkt_tx_lenchk #(
    parameter int LW      = 8,
    parameter int MIN_LEN = 5,
    parameter int MAX_LEN = 127
) (
    input  logic [LW-1:0] len_i,
    output logic          ok_o
);
    assign ok_o = (len_i >= LW'(MIN_LEN)) && (len_i <= LW'(MAX_LEN));
endmodule

// File: rtl/pkt_tx_crc.sv
module pkt_tx_crc
    import pkt_tx_pkg::*;
#(
    parameter int                DW   = 8,
    parameter int                CW   = CHK_W,
    parameter logic [CW-1:0]     POLY = CHK_POLY_REF,
    parameter logic [CW-1:0]     SEED = CHK_SEED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          upd_i,
    input  logic [DW-1:0] din_i,
    output logic [CW-1:0] crc_o
);
    logic [CW-1:0] crc_q;
    logic [CW-1:0] stage [DW+1];

    assign stage[0] = crc_q;

    // one shift step per data bit, least significant bit first
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign stage[b+1] = (stage[b][0] ^ din_i[b]) ? ((stage[b] >> 1) ^ POLY)
                                                     : (stage[b] >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (clr_i) crc_q <= SEED;
        else if (upd_i) crc_q <= stage[DW];
    end

    assign crc_o = crc_q;

    p_crc_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !upd_i) |=> $stable(crc_o));
endmodule

// File: rtl/pkt_tx_fsm.sv
module pkt_tx_fsm
    import pkt_tx_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          LW        = 8,
    parameter int          CW        = CHK_W,
    parameter int          PRE_BYTES = 4,
    parameter logic [7:0]  PRE_VAL   = 8'h00,
    parameter logic [7:0]  DELIM_VAL = 8'hA7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    input  logic          len_ok_i,
    input  logic [DW-1:0] in_data_i,
    input  logic          in_valid_i,
    input  logic [CW-1:0] crc_i,
    output logic          in_ready_o,
    output logic [DW-1:0] out_data_o,
    output logic          out_valid_o,
    output logic          out_sof_o,
    output logic          out_eof_o,
    output logic          len_err_o,
    output logic          crc_clr_o,
    output logic          crc_upd_o,
    output txf_state_e    state_o
);
    localparam int CHK_BYTES = CW / DW;
    localparam int PCW       = $clog2(PRE_BYTES + 1);
    localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_BYTES - 1);

    txf_state_e    state_q, state_d;
    logic [PCW-1:0] pre_cnt_q;
    logic [LW-1:0]  len_q;
    logic [LW-1:0]  mac_left_q;
    logic           err_q;
    logic           accept, reject, mac_xfer;

    assign accept   = (state_q == ST_IDLE) && start_i && len_ok_i;
    assign reject   = (state_q == ST_IDLE) && start_i && !len_ok_i;
    assign mac_xfer = (state_q == ST_MAC) && in_valid_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PRE;
            ST_PRE:    if (pre_cnt_q == PRE_LAST) state_d = ST_DELIM;
            ST_DELIM:  state_d = ST_LEN;
            ST_LEN:    state_d = ST_MAC;
            ST_MAC:    if (mac_xfer && mac_left_q == LW'(1)) state_d = ST_CHK_LO;
            ST_CHK_LO: state_d = ST_CHK_HI;
            ST_CHK_HI: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pre_cnt_q  <= '0;
            len_q      <= '0;
            mac_left_q <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= reject;
            if (accept) begin
                len_q      <= len_i;
                mac_left_q <= len_i - LW'(CHK_BYTES);
                pre_cnt_q  <= '0;
            end
            if (state_q == ST_PRE) pre_cnt_q <= pre_cnt_q + PCW'(1);
            if (mac_xfer)          mac_left_q <= mac_left_q - LW'(1);
        end
    end

    // outputs
    always_comb begin
        out_data_o  = '0;
        out_valid_o = 1'b0;
        out_sof_o   = 1'b0;
        out_eof_o   = 1'b0;
        in_ready_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                out_data_o  = DW'(PRE_VAL);
                out_valid_o = 1'b1;
                out_sof_o   = (pre_cnt_q == '0);
            end
            ST_DELIM: begin
                out_data_o  = DW'(DELIM_VAL);
                out_valid_o = 1'b1;
            end
            ST_LEN: begin
                out_data_o  = DW'(len_q);
                out_valid_o = 1'b1;
            end
            ST_MAC: begin
                in_ready_o  = 1'b1;
                out_data_o  = in_data_i;
                out_valid_o = in_valid_i;
            end
            ST_CHK_LO: begin
                out_data_o  = crc_i[DW-1:0];
                out_valid_o = 1'b1;
            end
            ST_CHK_HI: begin
                out_data_o  = crc_i[2*DW-1:DW];
                out_valid_o = 1'b1;
                out_eof_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assign len_err_o = err_q;
    assign crc_clr_o = accept;
    assign crc_upd_o = mac_xfer;
    assign state_o   = state_q;

    p_sof_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof_o |-> $past(state_q) == ST_IDLE);
    p_delim_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELIM) |-> ($past(state_q) == ST_PRE && $past(pre_cnt_q) == PRE_LAST));
    p_len_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(len_q));
    p_chk_after_mac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHK_LO) |-> ($past(state_q) == ST_MAC && $past(in_valid_i)));
    p_eof_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof_o |=> state_q == ST_IDLE);
    p_err_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> (state_q == ST_IDLE && !out_valid_o));
    p_markers_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_sof_o, out_eof_o}));
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import pkt_tx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int LW        = 8,
    parameter int PRE_BYTES = 4,
    parameter int MIN_LEN   = 5,
    parameter int MAX_LEN   = 127
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    output logic          len_err_o,
    input  logic [DW-1:0] in_data_i,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    output logic [DW-1:0] out_data_o,
    output logic          out_valid_o,
    output logic          out_sof_o,
    output logic          out_eof_o
);
    localparam int CW = CHK_W;

    logic          len_ok;
    logic          crc_clr, crc_upd;
    logic [CW-1:0] crc;
    txf_state_e    state;

    pkt_tx_lenchk #(
        .LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) u_lenchk (
        .len_i (len_i),
        .ok_o  (len_ok)
    );

    pkt_tx_crc #(
        .DW(DW), .CW(CW)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .upd_i (crc_upd),
        .din_i (in_data_i),
        .crc_o (crc)
    );

    pkt_tx_fsm #(
        .DW(DW), .LW(LW), .CW(CW), .PRE_BYTES(PRE_BYTES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .len_ok_i    (len_ok),
        .in_data_i   (in_data_i),
        .in_valid_i  (in_valid_i),
        .crc_i       (crc),
        .in_ready_o  (in_ready_o),
        .out_data_o  (out_data_o),
        .out_valid_o (out_valid_o),
        .out_sof_o   (out_sof_o),
        .out_eof_o   (out_eof_o),
        .len_err_o   (len_err_o),
        .crc_clr_o   (crc_clr),
        .crc_upd_o   (crc_upd),
        .state_o     (state)
    );

    p_crc_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE && $past(state) == ST_IDLE) |-> crc == CHK_SEED);
    p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !len_err_o);
endmodule

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] len_i = '0;
    logic       len_err_o;
    logic [7:0] in_data_i = '0;
    logic       in_valid_i = 1'b0;
    logic       in_ready_o;
    logic [7:0] out_data_o;
    logic       out_valid_o, out_sof_o, out_eof_o;

    always #2 clk = ~clk;

    pkt_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .len_err_o(len_err_o), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
        .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
        .out_sof_o(out_sof_o), .out_eof_o(out_eof_o)
    );

    typedef struct {
        logic [7:0] d;
        bit         mac;
        bit         sof;
        bit         eof;
        string      tag;
    } exp_t;

    exp_t       q[$];
    logic [7:0] frame_mac[$];
    string      chk_tag = "R7";
    bit         err_exp = 1'b0;
    int         vectors = 0;
    int         errs = 0;

    function automatic logic [15:0] crc_ref();
        logic [15:0] c = 16'h0000;
        foreach (frame_mac[i]) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ frame_mac[i][b]) c = (c >> 1) ^ 16'h8408;
                else                         c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic void push(logic [7:0] d, bit mac, bit sof, bit eof, string tag);
        exp_t e;
        e.d = d; e.mac = mac; e.sof = sof; e.eof = eof; e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic void load_expect(logic [7:0] len);
        logic [15:0] c = crc_ref();
        for (int i = 0; i < 4; i++) push(8'h00, 0, i == 0, 0, "R2");
        push(8'hA7, 0, 0, 0, "R3");
        push(len, 0, 0, 0, "R4");
        foreach (frame_mac[i]) push(frame_mac[i], 1, 0, 0, "R5");
        push(c[7:0], 0, 0, 0, chk_tag);
        push(c[15:8], 0, 0, 1, chk_tag);
    endfunction

    // cycle-by-cycle reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit idle;
            bit exp_rdy, exp_vld;
            idle = (q.size() == 0);
            vectors++;
            exp_rdy = !idle && q[0].mac;
            if (in_ready_o !== exp_rdy) begin
                errs++;
                $display("FAIL R6 in_ready got %b exp %b", in_ready_o, exp_rdy);
            end
            exp_vld = !idle && (!q[0].mac || in_valid_i);
            if (out_valid_o !== exp_vld) begin
                errs++;
                $display("FAIL %s out_valid got %b exp %b", idle ? "R10" : (q[0].mac ? "R5" : "R11"),
                         out_valid_o, exp_vld);
            end else if (exp_vld) begin
                if (out_data_o !== q[0].d || out_sof_o !== q[0].sof || out_eof_o !== q[0].eof) begin
                    errs++;
                    $display("FAIL %s data/sof/eof got %h/%b/%b exp %h/%b/%b", q[0].tag,
                             out_data_o, out_sof_o, out_eof_o, q[0].d, q[0].sof, q[0].eof);
                end
                void'(q.pop_front());
            end
            if (len_err_o !== err_exp) begin
                errs++;
                $display("FAIL R9 len_err got %b exp %b", len_err_o, err_exp);
            end
            err_exp = 1'b0;
            if (start_i && idle) begin
                if (len_i >= 8'd5 && len_i <= 8'd127) load_expect(len_i);
                else err_exp = 1'b1;
            end
        end
    end

    task automatic run_frame(input int len, input int seed, input bit gaps, input int inj);
        frame_mac.delete();
        for (int i = 0; i < len - 2; i++) frame_mac.push_back(8'((seed * 37 + i * 13 + 5) & 255));
        @(posedge clk); #1;
        start_i = 1'b1; len_i = 8'(len);
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int i = 0; i < len - 2; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid_i = 1'b0;
                repeat (2) begin @(posedge clk); #1; end
            end
            in_valid_i = 1'b1;
            in_data_i  = frame_mac[i];
            if (i == inj) begin
                start_i = 1'b1;   // R10: stray request mid-frame
                len_i   = (seed % 2 == 0) ? 8'd200 : 8'd9;
            end
            @(negedge clk);
            while (!in_ready_o) @(negedge clk);
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        in_valid_i = 1'b0;
        while (q.size() != 0) begin @(posedge clk); #1; end
        @(posedge clk); #1;
    endtask

    task automatic bad_len(input int len);
        @(posedge clk); #1;
        start_i = 1'b1; len_i = 8'(len);   // R9
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errs++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid_o !== 1'b0 || in_ready_o !== 1'b0 || len_err_o !== 1'b0) begin
            errs++;
            $display("FAIL R1 during reset got %b%b%b exp 000", out_valid_o, in_ready_o, len_err_o);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (out_valid_o !== 1'b0 || in_ready_o !== 1'b0 || len_err_o !== 1'b0) begin
            errs++;
            $display("FAIL R1 after reset got %b%b%b exp 000", out_valid_o, in_ready_o, len_err_o);
        end

        in_valid_i = 1'b1;                 // R6: valid held early must not transfer
        run_frame(5, 1, 0, -1);            // shortest legal frame
        run_frame(20, 2, 1, -1);           // input gaps, R5
        run_frame(127, 3, 0, -1);          // longest legal frame
        bad_len(4);
        bad_len(128);
        bad_len(0);
        bad_len(255);
        chk_tag = "R8";
        run_frame(12, 7, 0, -1);
        run_frame(12, 7, 1, -1);           // same content, same check bytes
        chk_tag = "R7";
        run_frame(10, 4, 0, 3);            // R10 stray start with bad length
        run_frame(9, 5, 1, 2);             // R10 stray start with legal length
        run_frame(6, 6, 0, -1);
        summary();
    end
endmodule